// File: doc/BRIEF.md
# Multi-Channel Periodic Down-Counter Bank

This peripheral holds a parameterised set of independent down-counters (six by default, 32 bits wide) behind a simple register bus with an address, write data, a write strobe and registered read data. Each channel has a control word, an interval register and a live count. While a channel runs it steps down once for every cycle in which the shared `tick` strobe is high. When it expires it reloads from its interval and latches its status bit, so it produces a periodic event. One enable register and one status register are shared by all channels. Each channel drives its own interrupt line, which is the enabled status bit of that channel.

A control bit chosen per channel sets what an interval write does. Either it loads the live counter at once, or it changes only the value used at the next reload. Status bits are cleared by writing ones. A small group of four 32-bit words at fixed offsets is plain storage with no behaviour attached.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every channel control register reads 0x4, every interval and count reads 0, the enable and status registers read 0, the four storage words read 0, and all `irq` outputs are low.
- R2: Byte-addressed map: enable at 0x0, status at 0x4. Channel n (n = 0..NCH-1) has control at 0x10+0x10*n, interval at +0x4 and count at +0x8. `rd_data` shows the register addressed in the previous cycle. Every other offset, including slot offset +0xC and misaligned addresses, reads 0.
- R3: With control bit 0 set, the count drops by one in each cycle where `tick` is high. With bit 0 clear, the count holds, whatever `tick` does.
- R4: A tick on a running channel whose count is 0 or 1 loads the count from the reload value and sets the channel's status bit (bit n). The period is therefore the interval value in ticks.
- R5: An interval write always sets the interval register and the reload value. If control bit 1 is set at the time of the write, the count is also loaded with the written value in the same cycle. If bit 1 is clear, the count is left alone.
- R6: After reset the reload value is all ones, so the first expiry from reset loads 0xFFFFFFFF into the count.
- R7: Writing status sets to 0 each bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R8: `irq[n]` equals status bit n AND enable bit n, one cycle after those bits change. The enable register holds only bits 0..NCH-1, and the upper bits read 0.
- R9: Writes to a channel's count offset have no effect on the count.
- R10: The four storage words at 0x90, 0x94, 0xA4 and 0xA8 each read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data for the previous cycle's address |
| tick | input | 1 | Prescaled count strobe, one step per high cycle |
| irq | output | NCH | Per-channel interrupt, enabled status |

## Verification
The bench builds the block with its defaults: six 32-bit channels and a 10-bit address. This covers every channel slot up to 0x6C and the storage words beyond the slots. Intervals of 1 and 5 ticks bring expiry, reload and a repeated period within a few cycles. The all-ones reload that follows reset is reached in one tick, because the count starts at zero. A tick and a status clear are also driven in the same cycle to exercise the set-over-clear priority.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int unsigned OFS_EN      = 'h0;
  localparam int unsigned OFS_ST      = 'h4;
  localparam int unsigned SLOT_BASE   = 'h10;
  localparam int unsigned SLOT_STRIDE = 'h10;
  localparam int unsigned SUB_CTRL    = 'h0;
  localparam int unsigned SUB_IVL     = 'h4;
  localparam int unsigned SUB_CNT     = 'h8;
  localparam int unsigned NSTORE      = 4;
  localparam int unsigned STORE_OFS [NSTORE] = '{'h90, 'h94, 'hA4, 'hA8};
  localparam int unsigned CTRL_RESET  = 'h4;
  localparam int unsigned BIT_RUN     = 0;
  localparam int unsigned BIT_AUTOLD  = 1;
endpackage

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic          ivl_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] ivl_q,
  output logic [DW-1:0] cnt_q,
  output logic          expire
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] reload_q;
  logic          run;
  logic          load_now;
  logic          at_end;

  assign run      = ctrl_q[BIT_RUN];
  assign load_now = ivl_we && ctrl_q[BIT_AUTOLD];
  assign at_end   = (cnt_q <= ONE);
  assign expire   = run && tick && at_end && !load_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= DW'(CTRL_RESET);
      ivl_q    <= '0;
      reload_q <= '1;
      cnt_q    <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (ivl_we) begin
        ivl_q    <= wdata;
        reload_q <= wdata;
      end
      if (load_now)
        cnt_q <= wdata;
      else if (run && tick)
        cnt_q <= at_end ? reload_q : cnt_q - ONE;
    end
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[BIT_RUN] && !load_now) |=> $stable(cnt_q)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[BIT_RUN] && tick && !load_now && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[BIT_RUN] && tick && !load_now && cnt_q <= ONE) |=> (cnt_q == $past(reload_q))); // R4
  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ivl_we && ctrl_q[BIT_AUTOLD]) |=> (cnt_q == $past(wdata))); // R5
endmodule

// File: rtl/ttb_irq.sv
module ttb_irq #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_we,
  input  logic           st_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] st_q,
  output logic [NCH-1:0] irq_q
);
  logic [NCH-1:0] clr_mask;

  assign clr_mask = st_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      st_q  <= (st_q & ~clr_mask) | expire;
      irq_q <= st_q & en_q;
    end
  end

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
    st_we |=> ((st_q & $past(wdata & ~expire)) == '0)); // R7
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
    (expire != '0) |=> ((st_q & $past(expire)) == $past(expire))); // R7
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    st_we |=> ((st_q & $past(st_q & ~wdata)) == $past(st_q & ~wdata))); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == $past(st_q & en_q))); // R8
endmodule

// File: rtl/ttb_store.sv
module ttb_store #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          we,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  q
);
  for (genvar k = 0; k < NREG; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        q[k] <= '0;
      else if (we[k])
        q[k] <= wdata;
    end

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst)
      we[k] |=> (q[k] == $past(wdata))); // R10
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import ttb_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic           tick,
  output logic [NCH-1:0] irq
);
  logic [31:0] addr_w;
  assign addr_w = 32'(addr);

  logic           en_hit, st_hit;
  logic [NCH-1:0] ctrl_hit, ivl_hit, cnt_hit, expire;
  logic [NSTORE-1:0] store_hit;

  logic [DW-1:0] ch_ctrl [NCH];
  logic [DW-1:0] ch_ivl  [NCH];
  logic [DW-1:0] ch_cnt  [NCH];

  logic [NCH-1:0] en_q, st_q;
  logic [NSTORE-1:0][DW-1:0] store_q;

  assign en_hit = (addr_w == OFS_EN);
  assign st_hit = (addr_w == OFS_ST);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned BASE = SLOT_BASE + SLOT_STRIDE * n;
    assign ctrl_hit[n] = (addr_w == BASE + SUB_CTRL);
    assign ivl_hit[n]  = (addr_w == BASE + SUB_IVL);
    assign cnt_hit[n]  = (addr_w == BASE + SUB_CNT);

    ttb_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ctrl_we (wr_en && ctrl_hit[n]),
      .ivl_we  (wr_en && ivl_hit[n]),
      .wdata   (wr_data),
      .ctrl_q  (ch_ctrl[n]),
      .ivl_q   (ch_ivl[n]),
      .cnt_q   (ch_cnt[n]),
      .expire  (expire[n])
    );
  end

  for (genvar k = 0; k < NSTORE; k++) begin : g_store_dec
    assign store_hit[k] = (addr_w == STORE_OFS[k]);
  end

  ttb_irq #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .en_we  (wr_en && en_hit),
    .st_we  (wr_en && st_hit),
    .wdata  (wr_data[NCH-1:0]),
    .expire (expire),
    .en_q   (en_q),
    .st_q   (st_q),
    .irq_q  (irq)
  );

  ttb_store #(.DW(DW), .NREG(NSTORE)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en ? store_hit : '0),
    .wdata (wr_data),
    .q     (store_q)
  );

  logic [DW-1:0] rd_next;
  logic          hit_any;

  always_comb begin
    rd_next = '0;
    hit_any = 1'b0;
    if (en_hit) begin
      rd_next = DW'(en_q);
      hit_any = 1'b1;
    end
    if (st_hit) begin
      rd_next = DW'(st_q);
      hit_any = 1'b1;
    end
    for (int n = 0; n < NCH; n++) begin
      if (ctrl_hit[n]) begin rd_next = ch_ctrl[n]; hit_any = 1'b1; end
      if (ivl_hit[n])  begin rd_next = ch_ivl[n];  hit_any = 1'b1; end
      if (cnt_hit[n])  begin rd_next = ch_cnt[n];  hit_any = 1'b1; end
    end
    for (int k = 0; k < NSTORE; k++) begin
      if (store_hit[k]) begin rd_next = store_q[k]; hit_any = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit_any |=> (rd_data == '0)); // R2
  AST_ONE_DECODE: assert property (@(posedge clk) disable iff (rst)
    $countones({en_hit, st_hit, ctrl_hit, ivl_hit, cnt_hit, store_hit}) <= 1); // R2
endmodule

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  localparam int NCH = 6;
  localparam int DW  = 32;
  localparam int AW  = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [AW-1:0]  addr = '0;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [DW-1:0]  rd_data;
  logic           tick = 1'b0;
  logic [NCH-1:0] irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_bank #(.NCH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .irq(irq)
  );

  function automatic logic [AW-1:0] slot(input int n, input int sub);
    return AW'(32'h10 + 32'h10 * n + sub);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_reg(input string req, input string what,
                            input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    bus_read(a, v);
    check(req, what, v, exp);
  endtask

  task automatic t_reset_state;
    for (int n = 0; n < NCH; n++) begin
      expect_reg("R1", "ctrl reset", slot(n, 0), 32'h4);
      expect_reg("R1", "interval reset", slot(n, 4), 32'h0);
      expect_reg("R1", "count reset", slot(n, 8), 32'h0);
    end
    expect_reg("R1", "enable reset", 10'h0, 32'h0);
    expect_reg("R1", "status reset", 10'h4, 32'h0);
    expect_reg("R1", "store reset 0x90", 10'h90, 32'h0);
    expect_reg("R1", "store reset 0xA8", 10'hA8, 32'h0);
    check("R1", "irq reset", DW'(irq), 32'h0);
  endtask

  task automatic t_reset_reload;
    bus_write(slot(2, 0), 32'h1);
    ticks(1);
    expect_reg("R6", "all-ones reload", slot(2, 8), 32'hFFFF_FFFF);
    expect_reg("R4", "status after first expiry", 10'h4, 32'h4);
    bus_write(slot(2, 0), 32'h0);
    bus_write(10'h4, 32'h4);
    expect_reg("R7", "status cleared", 10'h4, 32'h0);
  endtask

  task automatic t_interval_write;
    bus_write(slot(0, 0), 32'h2);
    bus_write(slot(0, 4), 32'd5);
    expect_reg("R5", "autoload count", slot(0, 8), 32'd5);
    bus_write(slot(1, 0), 32'h0);
    bus_write(slot(1, 4), 32'd7);
    expect_reg("R5", "no autoload count", slot(1, 8), 32'd0);
    expect_reg("R5", "interval stored", slot(1, 4), 32'd7);
  endtask

  task automatic t_count_and_period;
    bus_write(slot(0, 0), 32'h3);
    ticks(3);
    expect_reg("R3", "three steps", slot(0, 8), 32'd2);
    bus_write(slot(0, 0), 32'h2);
    ticks(4);
    expect_reg("R3", "stopped holds", slot(0, 8), 32'd2);
    bus_write(slot(0, 0), 32'h3);
    ticks(1);
    expect_reg("R3", "resume step", slot(0, 8), 32'd1);
    ticks(1);
    expect_reg("R4", "reload on expiry", slot(0, 8), 32'd5);
    expect_reg("R4", "status bit0", 10'h4, 32'h1);
    bus_write(10'h4, 32'h1);
    ticks(4);
    expect_reg("R4", "before second expiry", slot(0, 8), 32'd1);
    expect_reg("R4", "no status mid period", 10'h4, 32'h0);
    ticks(1);
    expect_reg("R4", "second expiry status", 10'h4, 32'h1);
    bus_write(slot(0, 0), 32'h2);
  endtask

  task automatic t_status_clear;
    bus_write(10'h4, 32'h0);
    expect_reg("R7", "zero write keeps", 10'h4, 32'h1);
    bus_write(10'h4, 32'h2);
    expect_reg("R7", "other-bit write keeps", 10'h4, 32'h1);
    bus_write(10'h4, 32'h1);
    expect_reg("R7", "one write clears", 10'h4, 32'h0);
    bus_write(slot(3, 0), 32'h2);
    bus_write(slot(3, 4), 32'd1);
    bus_write(slot(3, 0), 32'h3);
    @(negedge clk);
    addr = 10'h4; wr_data = 32'h8; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    bus_write(slot(3, 0), 32'h0);
    expect_reg("R7", "set beats clear", 10'h4, 32'h8);
  endtask

  task automatic t_irq;
    bus_write(10'h0, 32'h8);
    @(negedge clk);
    check("R8", "irq enabled ch3", DW'(irq), 32'h8);
    bus_write(10'h0, 32'h0);
    @(negedge clk);
    check("R8", "irq masked", DW'(irq), 32'h0);
    bus_write(10'h0, 32'hFFFF_FFFF);
    expect_reg("R8", "enable upper bits zero", 10'h0, 32'h3F);
    check("R8", "irq re-enabled", DW'(irq), 32'h8);
    bus_write(10'h4, 32'h8);
    @(negedge clk);
    check("R8", "irq after clear", DW'(irq), 32'h0);
  endtask

  task automatic t_count_readonly;
    bus_write(slot(0, 8), 32'h1234);
    expect_reg("R9", "count write ignored", slot(0, 8), 32'd5);
  endtask

  task automatic t_map;
    expect_reg("R2", "slot +0xC", slot(0, 12), 32'h0);
    expect_reg("R2", "offset 0x8", 10'h8, 32'h0);
    expect_reg("R2", "offset 0x80", 10'h80, 32'h0);
    expect_reg("R2", "offset 0x3FC", 10'h3FC, 32'h0);
    expect_reg("R2", "misaligned", slot(1, 5), 32'h0);
    expect_reg("R2", "last slot ctrl", 10'h60, 32'h4);
    expect_reg("R2", "slot1 interval", 10'h24, 32'd7);
  endtask

  task automatic t_store;
    bus_write(10'h90, 32'hA5A5_0001);
    bus_write(10'h94, 32'h5A5A_0002);
    bus_write(10'hA4, 32'hDEAD_0003);
    bus_write(10'hA8, 32'hBEEF_0004);
    expect_reg("R10", "store 0x90", 10'h90, 32'hA5A5_0001);
    expect_reg("R10", "store 0x94", 10'h94, 32'h5A5A_0002);
    expect_reg("R10", "store 0xA4", 10'hA4, 32'hDEAD_0003);
    expect_reg("R10", "store 0xA8", 10'hA8, 32'hBEEF_0004);
    expect_reg("R2", "gap 0x98", 10'h98, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_reset_reload();
    t_interval_write();
    t_count_and_period();
    t_status_clear();
    t_irq();
    t_count_readonly();
    t_map();
    t_store();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule